// File: doc/BRIEF.md
# TDM Serial Frame Transmitter

This block sends a time-division-multiplexed frame on one serial data lane. It divides the system clock into a bit clock and generates its own frame sync. The sync goes high at the start of each frame and stays high for one full slot word. A frame holds a programmable number of slots, each `W` bits long. A per-slot enable mask decides which slots carry data. Data starts a programmable 0, 1 or 2 bit periods after the frame sync rises and is sent most significant bit first.

Words come in through a one-deep holding register with a valid/ready handshake. `word_ready_o` is high exactly when the holding register is empty. A word is taken when `word_valid_i` and `word_ready_o` are both high at a clock edge. While the register is full, the producer must hold its word and wait. At the start of every enabled slot the shifter pulls the held word, which frees the register. If the register is empty at that moment, the slot is sent as zeros and a sticky underrun flag is raised. The holding register keeps its contents while the block is disabled. Loading a word before raising `en_i` therefore covers the first slot. `W` must be a power of two.

Top module: `tdm_tx`

## Requirements
- R1: During and right after reset, with `en_i` low, `word_ready_o`=1, `sclk_o`=0, `fsync_o`=0, `sdata_o`=0 and `underrun_o`=0.
- R2: While enabled, `sclk_o` has a period of `DIV` clocks and is high for `DIV-DIV/2` of them. `sdata_o` and `fsync_o` change only on the clock where `sclk_o` falls.
- R3: A frame lasts `num_slots_i*W` bit periods. `fsync_o` is high for the first `W` bit periods of every frame, and the first frame starts with the first bit period after `en_i` rises. A `num_slots_i` of 0 counts as 1.
- R4: The first data bit of slot 0 is sent `delay_i` bit periods after `fsync_o` rises. The code 3 behaves like 2.
- R5: An enabled slot sends its word MSB first, one bit per bit period. Slots are served in increasing index order, and each takes the next accepted word.
- R6: A slot whose `slot_mask_i` bit (bit n for slot n) is 0 sends zeros, takes no word and never raises `underrun_o`. Its `sdata_oe_o` is low when `hiz_idle_i`=1.
- R7: `word_ready_o` is high exactly when the holding register is empty. It drops on the clock after a transfer and stays low, with the held word unchanged, until an enabled slot takes it.
- R8: An enabled slot that starts while the holding register is empty sends all zeros and sets `underrun_o`. The flag stays set until reset.
- R9: `sdata_oe_o` is high during every enabled slot, and at all times when `hiz_idle_i`=0.
- R10: Dropping `en_i` returns `sclk_o`, `fsync_o` and `sdata_o` to 0 and keeps the held word. Raising it again starts a new frame at the first bit period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run enable for divider, framer and shifter |
| num_slots_i | input | SW+1 | Slots per frame (1 to MAX_SLOTS) |
| slot_mask_i | input | MAX_SLOTS | Per-slot enable, bit n for slot n |
| delay_i | input | 2 | Data delay after frame sync in bit periods |
| hiz_idle_i | input | 1 | Release the lane driver in disabled slots and idle bits |
| word_i | input | W | Word offered to the holding register |
| word_valid_i | input | 1 | Word offered |
| word_ready_o | output | 1 | Holding register empty |
| sclk_o | output | 1 | Bit clock |
| fsync_o | output | 1 | Frame sync, one word wide |
| sdata_o | output | 1 | Serial data |
| sdata_oe_o | output | 1 | Output enable for the serial lane |
| underrun_o | output | 1 | Sticky underrun flag |

## Verification
The hardest case to set up is a disabled slot that follows an enabled one while the holding register is deliberately left empty. That slot must stay silent and must not raise the underrun flag, even though a real underrun would occur if its mask bit were set. The bench gets there by starving the producer: it supplies exactly one word and then offers nothing. It stops observing at the last bit of the first frame, just before the next enabled slot would fetch. The same starvation, with both slots enabled, produces the real underrun for comparison.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;

  // Data delay codes in bit periods; code 3 folds onto the longest delay
  typedef enum logic [1:0] {
    DLY_NONE = 2'd0,
    DLY_ONE  = 2'd1,
    DLY_TWO  = 2'd2
  } dly_e;

  function automatic logic [1:0] fold_delay(input logic [1:0] code);
    return (code > 2'(DLY_TWO)) ? 2'(DLY_TWO) : code;
  endfunction

  // Slot-start event passed from framer to shifter
  typedef struct packed {
    logic load;
    logic [7:0] idx;
  } slot_evt_t;

endpackage

// File: rtl/tdm_tx_clkdiv.sv
module tdm_tx_clkdiv #(
  parameter int DIV = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o,
  output logic sclk_o
);
  localparam int DIV_E = (DIV < 2) ? 2 : DIV;
  localparam int CW    = $clog2(DIV_E);
  localparam int HALF  = DIV_E / 2;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cnt_q <= '0;
    else if (!run_i)                   cnt_q <= '0;
    else if (cnt_q == CW'(DIV_E - 1))  cnt_q <= '0;
    else                               cnt_q <= cnt_q + 1'b1;
  end

  // tick marks the last clock of a bit period; sclk falls right after it
  assign tick_o = run_i && (cnt_q == CW'(DIV_E - 1));
  assign sclk_o = run_i && (cnt_q >= CW'(HALF));
endmodule

// File: rtl/tdm_tx_framer.sv
module tdm_tx_framer
  import tdm_tx_pkg::*;
#(
  parameter int W         = 32,
  parameter int MAX_SLOTS = 4,
  localparam int SW = (MAX_SLOTS > 1) ? $clog2(MAX_SLOTS) : 1,
  localparam int BW = $clog2(W),
  localparam int PW = BW + SW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic          tick_i,
  input  logic [SW:0]   num_slots_i,
  input  logic [1:0]    delay_i,
  output logic          fsync_o,
  output logic          slot_load_o,
  output logic [SW-1:0] slot_idx_o
);
  logic          running_q, dstart_q;
  logic [PW:0]   fpos_q, fpos_n, dpos_n, frame_len, dly;
  logic [SW:0]   ns_eff;

  always_comb begin
    if (num_slots_i == '0)                          ns_eff = (SW+1)'(1);
    else if (num_slots_i > (SW+1)'(MAX_SLOTS))      ns_eff = (SW+1)'(MAX_SLOTS);
    else                                            ns_eff = num_slots_i;
    frame_len = {ns_eff, {BW{1'b0}}};
    dly       = (PW+1)'(fold_delay(delay_i));
    if (!running_q)                          fpos_n = '0;
    else if (fpos_q == frame_len - 1'b1)     fpos_n = '0;
    else                                     fpos_n = fpos_q + 1'b1;
    // data position trails the frame position by the delay
    if (fpos_n >= dly) dpos_n = fpos_n - dly;
    else               dpos_n = fpos_n + frame_len - dly;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running_q <= 1'b0;
      dstart_q  <= 1'b0;
      fpos_q    <= '0;
    end else if (!run_i) begin
      running_q <= 1'b0;
      dstart_q  <= 1'b0;
      fpos_q    <= '0;
    end else if (tick_i) begin
      running_q <= 1'b1;
      fpos_q    <= fpos_n;
      if (dpos_n == '0) dstart_q <= 1'b1;
    end
  end

  assign slot_load_o = tick_i && (dpos_n[BW-1:0] == '0) && ((dpos_n == '0) || dstart_q);
  assign slot_idx_o  = dpos_n[PW-1:BW];
  assign fsync_o     = running_q && (fpos_q < (PW+1)'(W));
endmodule

// File: rtl/tdm_tx_shifter.sv
module tdm_tx_shifter #(
  parameter int W         = 32,
  parameter int MAX_SLOTS = 4,
  localparam int SW = (MAX_SLOTS > 1) ? $clog2(MAX_SLOTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run_i,
  input  logic                 tick_i,
  input  logic                 slot_load_i,
  input  logic [SW-1:0]        slot_idx_i,
  input  logic [MAX_SLOTS-1:0] slot_mask_i,
  input  logic [W-1:0]         word_i,
  input  logic                 word_valid_i,
  output logic                 word_ready_o,
  output logic                 sdata_o,
  output logic                 drive_o,
  output logic                 underrun_o
);
  logic [W-1:0] hold_q, sh_q;
  logic         full_q, drive_q, urun_q;
  logic         act, take, accept;

  always_comb begin
    act = 1'b0;
    for (int s = 0; s < MAX_SLOTS; s++)
      if (slot_idx_i == SW'(s)) act = slot_mask_i[s];
    take   = slot_load_i && act && full_q;
    accept = word_valid_i && !full_q;
  end

  // holding register: one deep, kept across disable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      hold_q <= '0;
    end else if (take) begin
      full_q <= 1'b0;
    end else if (accept) begin
      full_q <= 1'b1;
      hold_q <= word_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      drive_q <= 1'b0;
      urun_q  <= 1'b0;
    end else if (!run_i) begin
      sh_q    <= '0;
      drive_q <= 1'b0;
    end else if (slot_load_i) begin
      drive_q <= act;
      sh_q    <= take ? hold_q : '0;
      if (act && !full_q) urun_q <= 1'b1;
    end else if (tick_i) begin
      sh_q <= {sh_q[W-2:0], 1'b0};
    end
  end

  assign word_ready_o = !full_q;
  assign sdata_o      = drive_q && sh_q[W-1];
  assign drive_o      = drive_q;
  assign underrun_o   = urun_q;
endmodule

// File: rtl/tdm_tx.sv
module tdm_tx #(
  parameter int W         = 32,
  parameter int MAX_SLOTS = 4,
  parameter int DIV       = 5,
  localparam int SW = (MAX_SLOTS > 1) ? $clog2(MAX_SLOTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en_i,
  input  logic [SW:0]          num_slots_i,
  input  logic [MAX_SLOTS-1:0] slot_mask_i,
  input  logic [1:0]           delay_i,
  input  logic                 hiz_idle_i,
  input  logic [W-1:0]         word_i,
  input  logic                 word_valid_i,
  output logic                 word_ready_o,
  output logic                 sclk_o,
  output logic                 fsync_o,
  output logic                 sdata_o,
  output logic                 sdata_oe_o,
  output logic                 underrun_o
);
  logic          tick, slot_load, drive;
  logic [SW-1:0] slot_idx;

  tdm_tx_clkdiv #(.DIV(DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .run_i(en_i), .tick_o(tick), .sclk_o(sclk_o)
  );

  tdm_tx_framer #(.W(W), .MAX_SLOTS(MAX_SLOTS)) u_frm (
    .clk(clk), .rst_n(rst_n), .run_i(en_i), .tick_i(tick),
    .num_slots_i(num_slots_i), .delay_i(delay_i), .fsync_o(fsync_o),
    .slot_load_o(slot_load), .slot_idx_o(slot_idx)
  );

  tdm_tx_shifter #(.W(W), .MAX_SLOTS(MAX_SLOTS)) u_shf (
    .clk(clk), .rst_n(rst_n), .run_i(en_i), .tick_i(tick),
    .slot_load_i(slot_load), .slot_idx_i(slot_idx), .slot_mask_i(slot_mask_i),
    .word_i(word_i), .word_valid_i(word_valid_i), .word_ready_o(word_ready_o),
    .sdata_o(sdata_o), .drive_o(drive), .underrun_o(underrun_o)
  );

  assign sdata_oe_o = drive || !hiz_idle_i;
endmodule

// File: rtl/tdm_tx_chk.sv
module tdm_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic en_i,
  input logic hiz_idle_i,
  input logic word_valid_i,
  input logic word_ready_o,
  input logic sclk_o,
  input logic fsync_o,
  input logic sdata_o,
  input logic sdata_oe_o,
  input logic underrun_o
);
  assert_bitedge_R2: assert property (@(posedge clk) disable iff (!rst_n || !en_i)
    ($past(en_i) && (!$stable(sdata_o) || !$stable(fsync_o))) |-> $fell(sclk_o));

  assert_ready_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid_i && word_ready_o) |=> !word_ready_o);

  assert_sticky_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_o |=> underrun_o);

  assert_lane_driven_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !hiz_idle_i |-> sdata_oe_o);
endmodule

bind tdm_tx tdm_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en_i(en_i), .hiz_idle_i(hiz_idle_i),
  .word_valid_i(word_valid_i), .word_ready_o(word_ready_o), .sclk_o(sclk_o),
  .fsync_o(fsync_o), .sdata_o(sdata_o), .sdata_oe_o(sdata_oe_o),
  .underrun_o(underrun_o)
);

// File: tb/tdm_tx_test.sv
`timescale 1ns/1ps
module tdm_tx_test;
  localparam int W = 32, MAXS = 4, DIV = 5, SW = 2;

  logic clk = 0, rst_n = 0, en_i = 0, hiz_idle_i = 0, word_valid_i = 0;
  logic [SW:0] num_slots_i = 3'd2;
  logic [MAXS-1:0] slot_mask_i = 4'b0011;
  logic [1:0] delay_i = 2'd0;
  logic [W-1:0] word_i = '0;
  logic word_ready_o, sclk_o, fsync_o, sdata_o, sdata_oe_o, underrun_o;

  tdm_tx #(.W(W), .MAX_SLOTS(MAXS), .DIV(DIV)) uut (.*);

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      summary();
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  // producer: offers feed_w[feed_idx] until taken
  logic feed_on = 0, acc = 0;
  int feed_n = 0, feed_idx = 0;
  logic [W-1:0] feed_w [0:15];
  always @(negedge clk) begin
    if (feed_on) begin
      if (acc) feed_idx++;
      if (feed_idx < feed_n) begin
        word_valid_i = 1; word_i = feed_w[feed_idx]; acc = word_ready_o;
      end else begin
        word_valid_i = 0; acc = 0;
      end
    end else begin
      word_valid_i = 0; acc = 0;
    end
  end

  // capture one sample per bit period at the sclk rise
  logic cap_on = 0, sclk_prev = 0;
  int cap_n = 0;
  logic bits [0:511], fs [0:511], oe [0:511];
  int rise_t [0:511];
  always @(negedge clk) begin
    if (cap_on && sclk_o && !sclk_prev && cap_n < 512) begin
      bits[cap_n] = sdata_o; fs[cap_n] = fsync_o; oe[cap_n] = sdata_oe_o;
      rise_t[cap_n] = cyc; cap_n++;
    end
    sclk_prev = sclk_o;
  end

  typedef struct packed { logic [2:0] ns; logic [3:0] mask; logic [1:0] dly; logic hiz; } vec_t;
  localparam vec_t VECS [6] = '{
    '{3'd2, 4'b0011, 2'd2, 1'b0},
    '{3'd2, 4'b0011, 2'd0, 1'b0},
    '{3'd2, 4'b0011, 2'd1, 1'b0},
    '{3'd4, 4'b0101, 2'd1, 1'b1},
    '{3'd3, 4'b0010, 2'd3, 1'b0},
    '{3'd1, 4'b0001, 2'd0, 1'b0}
  };

  function automatic logic [31:0] gen(input int v, input int i);
    logic [31:0] m = 32'h2468_ACE1 * (v * 8 + i + 1);
    return 32'h8000_0001 | (m & 32'h7FFF_FFFE);
  endfunction

  task automatic reset_dut();
    en_i = 0; feed_on = 0; cap_on = 0; rst_n = 0; hiz_idle_i = 0;
    step(); step();
    check(word_ready_o && !sclk_o && !fsync_o && !sdata_o && !underrun_o, "R1 in reset",
          {27'd0, word_ready_o, sclk_o, fsync_o, sdata_o, underrun_o}, 32'h10);
    rst_n = 1; step();
    check(word_ready_o && !sclk_o && !fsync_o && !sdata_o && !underrun_o, "R1 after reset",
          {27'd0, word_ready_o, sclk_o, fsync_o, sdata_o, underrun_o}, 32'h10);
    feed_idx = 0; feed_n = 0; cap_n = 0;
  endtask

  task automatic preload_and_start();
    feed_on = 1;
    while (word_ready_o) step();
    repeat (5) step();
    check(!word_ready_o, "R7 back-pressure while full", word_ready_o, 0);
    cap_n = 0; cap_on = 1; en_i = 1;
  endtask

  function automatic logic [31:0] slot_word(input int base);
    logic [31:0] w = 0;
    for (int b = 0; b < W; b++) w = {w[30:0], bits[base + b]};
    return w;
  endfunction

  task automatic run_vec(input int v, input vec_t c);
    int d, L, k, idx, bad;
    logic [31:0] w, e;
    reset_dut();
    num_slots_i = c.ns; slot_mask_i = c.mask; delay_i = c.dly; hiz_idle_i = c.hiz;
    d = (c.dly > 2) ? 2 : int'(c.dly);
    L = int'(c.ns) * W;
    k = 0;
    for (int s = 0; s < int'(c.ns); s++) if (c.mask[s]) k++;
    for (int i = 0; i < 2 * k; i++) feed_w[i] = gen(v, i);
    feed_n = 2 * k;
    preload_and_start();
    while (cap_n < 1 + d + 2 * L) step();
    check(!underrun_o, "R8 no underrun when fed", underrun_o, 0);
    check(fs[1] && !fs[0], "R3 frame starts at first bit", {fs[0], fs[1]}, 2'b01);
    bad = 0;
    for (int i = 0; i < L; i++) if (fs[1 + i] != (i < W)) bad++;
    if (!fs[1 + L]) bad++;
    check(bad == 0, "R3 sync width and frame length", bad, 0);
    check(rise_t[2] - rise_t[1] == DIV, "R2 bit period", rise_t[2] - rise_t[1], DIV);
    idx = 0;
    for (int fr = 0; fr < 2; fr++)
      for (int s = 0; s < int'(c.ns); s++) begin
        w = slot_word(1 + d + fr * L + s * W);
        e = c.mask[s] ? gen(v, idx) : 32'h0;
        if (c.mask[s]) idx++;
        check(w == e, c.mask[s] ? "R4 R5 slot data" : "R6 masked slot zero", w, e);
        bad = 0;
        for (int b = 0; b < W; b++)
          if (oe[1 + d + fr * L + s * W + b] != (c.mask[s] || !c.hiz)) bad++;
        check(bad == 0, c.mask[s] ? "R9 enable in active slot" : "R6 release in masked slot", bad, 0);
      end
    en_i = 0; cap_on = 0; step(); step();
    check(!sclk_o && !fsync_o && !sdata_o, "R10 idle after disable",
          {sclk_o, fsync_o, sdata_o}, 0);
  endtask

  initial begin
    int hc, L;
    logic [31:0] w;
    for (int v = 0; v < 6; v++) run_vec(v, VECS[v]);

    // underrun: both slots enabled, only one word ever supplied
    reset_dut();
    num_slots_i = 2; slot_mask_i = 4'b0011; delay_i = 0; hiz_idle_i = 0;
    L = 2 * W;
    feed_w[0] = 32'hC0FF_EE01; feed_n = 1;
    preload_and_start();
    while (cap_n < 1 + L) step();
    w = slot_word(1);
    check(w == 32'hC0FF_EE01, "R7 preloaded word in slot 0", w, 32'hC0FF_EE01);
    w = slot_word(1 + W);
    check(w == 0, "R8 underrun slot sends zeros", w, 0);
    check(underrun_o, "R8 flag raised", underrun_o, 1);
    while (cap_n < 1 + 2 * L) step();
    w = slot_word(1 + L);
    check(w == 0, "R8 second underrun zeros", w, 0);
    hc = 0;
    for (int i = 0; i < 10 * DIV; i++) begin step(); hc += int'(sclk_o); end
    check(hc == 10 * (DIV - DIV / 2), "R2 high time", hc, 10 * (DIV - DIV / 2));
    en_i = 0; step(); step();
    check(underrun_o, "R8 flag sticky through disable", underrun_o, 1);
    reset_dut();

    // masked slot after an empty register: no underrun
    num_slots_i = 2; slot_mask_i = 4'b0001; delay_i = 0; hiz_idle_i = 1;
    feed_w[0] = 32'hA1B2_C3D4; feed_w[1] = 32'h9876_5431; feed_n = 1;
    preload_and_start();
    while (cap_n < 1 + L) step();
    w = slot_word(1 + W);
    check(w == 0, "R6 masked slot zeros", w, 0);
    check(!underrun_o, "R6 masked slot no underrun", underrun_o, 0);
    check(!oe[1 + W] && !oe[L], "R6 lane released", {oe[1 + W], oe[L]}, 0);
    en_i = 0; cap_on = 0; step(); step();
    check(!sclk_o && !fsync_o && !sdata_o, "R10 idle", {sclk_o, fsync_o, sdata_o}, 0);
    feed_n = 2;
    preload_and_start();
    while (cap_n < 1 + L) step();
    check(fs[1] && !fs[0], "R10 restart frame", {fs[0], fs[1]}, 2'b01);
    w = slot_word(1);
    check(w == 32'h9876_5431, "R10 restart data", w, 32'h9876_5431);
    en_i = 0; cap_on = 0; feed_on = 0; step();

    summary();
    $finish;
  end
endmodule